// File: doc/BRIEF.md
# Banked Flash Concurrency Arbiter

This block sits in front of a multi-bank flash model and decides, one request per cycle, whether a bus operation may go ahead. It holds the state that matters for concurrency. That state is the single bank that is actively programming or erasing, one parked (suspended) operation, and one program or erase setup that still waits for its confirm cycle. Each request carries an operation code, a bank index and a block index. The block answers one cycle later with either a grant pulse or an error pulse with a reason code, and it updates its state on the same clock edge.

The rules let code run from one bank while another bank is being written. Array reads go to any bank that is not actively busy, with no wait. A running operation can be parked so that its own bank becomes readable. A parked erase leaves room for a program to another block. Reads may fall between the two cycles of a program or erase command without losing the setup. Reads of the special read spaces are refused while bank `PARAM_BANK` is actively busy. These spaces are the query table, the one-time-programmable area and the identifier. Completion of the running operation is signalled by a pulse from the timing model.

Top module: `flash_dualop_arb`

## Requirements
- R1: A program setup (op 2) or erase setup (op 3) that arrives while an operation is active is rejected with reason 1 (busy). A confirm (op 4) that arrives while an operation is active is also rejected with reason 1.
- R2: An array read (op 0) to a bank that is not actively programming or erasing is granted in the next cycle, whatever the other banks are doing.
- R3: An array read (op 0) to the bank that is actively programming or erasing is rejected with reason 1.
- R4: A suspend (op 5) moves the active operation to the parked slot. The busy flag clears, the suspend flag sets, and array reads to the parked bank are granted. A suspend with nothing active, or with an operation already parked, is rejected with reason 3 (sequence).
- R5: While an erase is parked, a program setup and confirm to another block are granted. A program setup to the parked block (same bank and block) is rejected with reason 1. An erase setup while anything is parked is rejected with reason 1. A program setup while a program is parked is rejected with reason 1.
- R6: Array and special-space reads between a setup and its confirm leave the setup intact. The confirm then starts the operation on the bank given at setup time, and the busy-bank output shows that bank.
- R7: A special-space read (op 1; its bank field is ignored) is rejected with reason 2 (space conflict) while bank PARAM_BANK is active. It is granted while another bank is active, and while the operation on PARAM_BANK is parked.
- R8: A resume (op 6) is granted only when an operation is parked and none is active. It makes the parked operation active again on its bank and clears the suspend flag. Otherwise it is rejected with reason 3.
- R9: A completion pulse clears the active operation. It has no effect when nothing is active. It takes effect before a request in the same cycle is judged.
- R10: A confirm with no pending setup is rejected with reason 1. A granted confirm consumes the pending setup.
- R11: After reset, busy, suspend, grant and error are all low.
- R12: Every request other than op 7 (idle) gets exactly one response in the next cycle: grant, or error with a nonzero reason. Op 7 gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0 read array, 1 read special space, 2 program setup, 3 erase setup, 4 confirm, 5 suspend, 6 resume, 7 idle) |
| req_bank | input | BANK_W | Target bank index |
| req_blk | input | BLK_W | Target block index within the bank |
| done_pulse | input | 1 | The active operation has finished |
| gnt | output | 1 | Request of the previous cycle granted |
| err | output | 1 | Request of the previous cycle rejected |
| err_code | output | 2 | Reject reason: 1 busy, 2 space conflict, 3 sequence |
| busy | output | 1 | An operation is actively programming or erasing |
| busy_bank | output | BANK_W | Bank of the active operation (valid while busy) |
| busy_erase | output | 1 | Active operation is an erase (valid while busy) |
| susp | output | 1 | An operation is parked |
| susp_bank | output | BANK_W | Bank of the parked operation (valid while susp) |
| susp_erase | output | 1 | Parked operation is an erase (valid while susp) |

## Verification
The bench aims at the places where the slots interact. One case programs a different block while an erase is parked, and another programs the parked block itself. A design that compares only banks would reject the first, and one that ignores the parked slot would accept the second. Reads placed between setup and confirm catch a design that clears the pending setup on any request. A resume attempted while the program is still running catches a design that would leave two operations active. A completion pulse that lands in the same cycle as a read of the busy bank catches a design that judges against stale state and rejects a read that should pass.

// File: rtl/flash_dualop_pkg.sv
package flash_dualop_pkg;

  typedef enum logic [2:0] {
    OP_RD_ARRAY    = 3'd0,
    OP_RD_SPACE    = 3'd1,
    OP_PROG_SETUP  = 3'd2,
    OP_ERASE_SETUP = 3'd3,
    OP_CONFIRM     = 3'd4,
    OP_SUSPEND     = 3'd5,
    OP_RESUME      = 3'd6,
    OP_IDLE        = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    RSN_NONE  = 2'd0,
    RSN_BUSY  = 2'd1,
    RSN_SPACE = 2'd2,
    RSN_SEQ   = 2'd3
  } rsn_e;

  // state-changing actions requested by the decision logic (at most one set)
  typedef struct packed {
    logic load_pend;
    logic start;
    logic park;
    logic unpark;
  } act_t;

endpackage

// File: rtl/dualop_decide.sv
module dualop_decide
  import flash_dualop_pkg::*;
#(
  parameter int NBANK      = 8,
  parameter int BANK_W     = $clog2(NBANK),
  parameter int BLK_W      = 4,
  parameter int PARAM_BANK = 0
) (
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [BLK_W-1:0]  req_blk,
  input  logic              act_v,
  input  logic [BANK_W-1:0] act_bank,
  input  logic              sus_v,
  input  logic              sus_erase,
  input  logic [BANK_W-1:0] sus_bank,
  input  logic [BLK_W-1:0]  sus_blk,
  input  logic              pend_v,
  output logic              ok,
  output logic              rej,
  output rsn_e              rsn,
  output act_t              acts
);

  logic [NBANK-1:0] bank_hot;

  // per-bank "actively busy" mask
  for (genvar g = 0; g < NBANK; g++) begin : g_hot
    assign bank_hot[g] = act_v && (act_bank == BANK_W'(g));
  end

  logic same_blk_as_parked;
  assign same_blk_as_parked = (sus_bank == req_bank) && (sus_blk == req_blk);

  always_comb begin
    ok   = 1'b0;
    rej  = 1'b0;
    rsn  = RSN_NONE;
    acts = '0;
    if (req_valid) begin
      case (op_e'(req_op))
        OP_RD_ARRAY: begin
          if (bank_hot[req_bank]) begin rej = 1'b1; rsn = RSN_BUSY; end
          else                          ok  = 1'b1;
        end
        OP_RD_SPACE: begin
          if (bank_hot[PARAM_BANK]) begin rej = 1'b1; rsn = RSN_SPACE; end
          else                            ok  = 1'b1;
        end
        OP_PROG_SETUP: begin
          if (act_v || (sus_v && (!sus_erase || same_blk_as_parked))) begin
            rej = 1'b1; rsn = RSN_BUSY;
          end else begin
            ok = 1'b1; acts.load_pend = 1'b1;
          end
        end
        OP_ERASE_SETUP: begin
          if (act_v || sus_v) begin rej = 1'b1; rsn = RSN_BUSY; end
          else begin ok = 1'b1; acts.load_pend = 1'b1; end
        end
        OP_CONFIRM: begin
          if (!pend_v || act_v) begin rej = 1'b1; rsn = RSN_BUSY; end
          else begin ok = 1'b1; acts.start = 1'b1; end
        end
        OP_SUSPEND: begin
          if (!act_v || sus_v) begin rej = 1'b1; rsn = RSN_SEQ; end
          else begin ok = 1'b1; acts.park = 1'b1; end
        end
        OP_RESUME: begin
          if (!sus_v || act_v) begin rej = 1'b1; rsn = RSN_SEQ; end
          else begin ok = 1'b1; acts.unpark = 1'b1; end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dualop_track.sv
module dualop_track
  import flash_dualop_pkg::*;
#(
  parameter int NBANK  = 8,
  parameter int BANK_W = $clog2(NBANK),
  parameter int BLK_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_pulse,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [BLK_W-1:0]  req_blk,
  input  logic              req_erase,
  input  act_t              acts,
  input  logic              ok,
  input  logic              rej,
  input  rsn_e              rsn,
  // state seen by the decision logic (completion already applied)
  output logic              eff_act_v,
  output logic [BANK_W-1:0] act_bank,
  output logic              act_erase,
  output logic              sus_v,
  output logic [BANK_W-1:0] sus_bank,
  output logic [BLK_W-1:0]  sus_blk,
  output logic              sus_erase,
  output logic              pend_v,
  // registered responses and status
  output logic              act_v,
  output logic              gnt_q,
  output logic              err_q,
  output logic [1:0]        code_q
);

  logic [BLK_W-1:0]  act_blk;
  logic [BANK_W-1:0] pend_bank;
  logic [BLK_W-1:0]  pend_blk;
  logic              pend_erase;

  assign eff_act_v = act_v && !done_pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_v      <= 1'b0;
      act_bank   <= '0;
      act_blk    <= '0;
      act_erase  <= 1'b0;
      sus_v      <= 1'b0;
      sus_bank   <= '0;
      sus_blk    <= '0;
      sus_erase  <= 1'b0;
      pend_v     <= 1'b0;
      pend_bank  <= '0;
      pend_blk   <= '0;
      pend_erase <= 1'b0;
      gnt_q      <= 1'b0;
      err_q      <= 1'b0;
      code_q     <= RSN_NONE;
    end else begin
      gnt_q  <= ok;
      err_q  <= rej;
      code_q <= rej ? rsn : RSN_NONE;
      act_v  <= eff_act_v;
      if (acts.load_pend) begin
        pend_v     <= 1'b1;
        pend_bank  <= req_bank;
        pend_blk   <= req_blk;
        pend_erase <= req_erase;
      end
      if (acts.start) begin
        act_v     <= 1'b1;
        act_bank  <= pend_bank;
        act_blk   <= pend_blk;
        act_erase <= pend_erase;
        pend_v    <= 1'b0;
      end
      if (acts.park) begin
        sus_v     <= 1'b1;
        sus_bank  <= act_bank;
        sus_blk   <= act_blk;
        sus_erase <= act_erase;
        act_v     <= 1'b0;
      end
      if (acts.unpark) begin
        act_v     <= 1'b1;
        act_bank  <= sus_bank;
        act_blk   <= sus_blk;
        act_erase <= sus_erase;
        sus_v     <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/flash_dualop_arb.sv
module flash_dualop_arb
  import flash_dualop_pkg::*;
#(
  parameter int NBANK      = 8,
  parameter int BANK_W     = $clog2(NBANK),
  parameter int BLK_W      = 4,
  parameter int PARAM_BANK = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [BLK_W-1:0]  req_blk,
  input  logic              done_pulse,
  output logic              gnt,
  output logic              err,
  output logic [1:0]        err_code,
  output logic              busy,
  output logic [BANK_W-1:0] busy_bank,
  output logic              busy_erase,
  output logic              susp,
  output logic [BANK_W-1:0] susp_bank,
  output logic              susp_erase
);

  logic              eff_act_v, sus_v, sus_erase, pend_v, ok, rej, act_v, act_erase;
  logic [BANK_W-1:0] act_bank, sus_bank;
  logic [BLK_W-1:0]  sus_blk;
  rsn_e              rsn;
  act_t              acts;

  dualop_decide #(
    .NBANK(NBANK), .BANK_W(BANK_W), .BLK_W(BLK_W), .PARAM_BANK(PARAM_BANK)
  ) u_decide (
    .req_valid(req_valid), .req_op(req_op), .req_bank(req_bank), .req_blk(req_blk),
    .act_v(eff_act_v), .act_bank(act_bank), .sus_v(sus_v), .sus_erase(sus_erase),
    .sus_bank(sus_bank), .sus_blk(sus_blk), .pend_v(pend_v),
    .ok(ok), .rej(rej), .rsn(rsn), .acts(acts)
  );

  dualop_track #(
    .NBANK(NBANK), .BANK_W(BANK_W), .BLK_W(BLK_W)
  ) u_track (
    .clk(clk), .rst(rst), .done_pulse(done_pulse),
    .req_bank(req_bank), .req_blk(req_blk),
    .req_erase(req_op == OP_ERASE_SETUP),
    .acts(acts), .ok(ok), .rej(rej), .rsn(rsn),
    .eff_act_v(eff_act_v), .act_bank(act_bank), .act_erase(act_erase),
    .sus_v(sus_v), .sus_bank(sus_bank), .sus_blk(sus_blk), .sus_erase(sus_erase),
    .pend_v(pend_v), .act_v(act_v),
    .gnt_q(gnt), .err_q(err), .code_q(err_code)
  );

  assign busy       = act_v;
  assign busy_bank  = act_bank;
  assign busy_erase = act_erase;
  assign susp       = sus_v;
  assign susp_bank  = sus_bank;
  assign susp_erase = sus_erase;

endmodule

// File: rtl/flash_dualop_chk.sv
module flash_dualop_chk #(
  parameter int NBANK      = 8,
  parameter int BANK_W     = $clog2(NBANK),
  parameter int PARAM_BANK = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [2:0]        req_op,
  input logic [BANK_W-1:0] req_bank,
  input logic              done_pulse,
  input logic              gnt,
  input logic              err,
  input logic [1:0]        err_code,
  input logic              busy,
  input logic [BANK_W-1:0] busy_bank
);

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (rst) !(gnt && err)); // R12
  AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (rst) err |-> (err_code != 2'd0)); // R12
  AST_SETUP_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_op == 3'd2 || req_op == 3'd3) && busy && !done_pulse)
    |=> (err && err_code == 2'd1)); // R1
  AST_FREE_READ: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd0 && !(busy && busy_bank == req_bank)) |=> gnt); // R2
  AST_SPACE_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd1 && busy && busy_bank == BANK_W'(PARAM_BANK) && !done_pulse)
    |=> (err && err_code == 2'd2)); // R7
  AST_SUSPEND_IDLE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd5 && !busy) |=> (err && err_code == 2'd3)); // R4
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (busy && done_pulse && !(req_valid && (req_op == 3'd4 || req_op == 3'd6))) |=> !busy); // R9
  AST_BUSY_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid && (req_op == 3'd4 || req_op == 3'd6))); // R6

endmodule

bind flash_dualop_arb flash_dualop_chk #(
  .NBANK(NBANK), .BANK_W(BANK_W), .PARAM_BANK(PARAM_BANK)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_bank(req_bank),
  .done_pulse(done_pulse), .gnt(gnt), .err(err), .err_code(err_code),
  .busy(busy), .busy_bank(busy_bank)
);

// File: tb/flash_dualop_arb_bench.sv
module flash_dualop_arb_bench;
  localparam int NBANK = 8;
  localparam int BANK_W = 3;
  localparam int BLK_W = 4;

  localparam logic [2:0] RD = 3'd0, RDS = 3'd1, PSET = 3'd2, ESET = 3'd3,
                         CONF = 3'd4, SUSP = 3'd5, RES = 3'd6;
  localparam logic [1:0] C_OK = 2'd0, C_BUSY = 2'd1, C_SPACE = 2'd2, C_SEQ = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_op = 3'd7;
  logic [BANK_W-1:0] req_bank = '0;
  logic [BLK_W-1:0] req_blk = '0;
  logic done_pulse = 1'b0;
  logic gnt, err, busy, busy_erase, susp, susp_erase;
  logic [1:0] err_code;
  logic [BANK_W-1:0] busy_bank, susp_bank;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  flash_dualop_arb #(.NBANK(NBANK), .BLK_W(BLK_W), .PARAM_BANK(0)) u_flash_dualop_arb (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_bank(req_bank),
    .req_blk(req_blk), .done_pulse(done_pulse), .gnt(gnt), .err(err), .err_code(err_code),
    .busy(busy), .busy_bank(busy_bank), .busy_erase(busy_erase), .susp(susp),
    .susp_bank(susp_bank), .susp_erase(susp_erase)
  );

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one request (optionally with a completion pulse), sample the response
  task automatic send(input logic [2:0] op, input int bank, input int blk, input bit dn,
                      input bit exp_g, input logic [1:0] exp_c, input string tag);
    logic [3:0] actv, expv;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_bank = BANK_W'(bank); req_blk = BLK_W'(blk);
    done_pulse = dn;
    @(posedge clk); #1;
    req_valid = 1'b0; req_op = 3'd7; done_pulse = 1'b0;
    actv = {gnt, err, err_code};
    expv = {exp_g, !exp_g, exp_g ? C_OK : exp_c};
    check(actv == expv, tag, int'(actv), int'(expv));
  endtask

  task automatic finish_op();
    @(negedge clk); done_pulse = 1'b1;
    @(posedge clk); #1; done_pulse = 1'b0;
  endtask

  task automatic t_reset();
    check({busy, susp, gnt, err} == 4'b0, "R11 reset state", int'({busy, susp, gnt, err}), 0);
  endtask

  task automatic t_dual_read();
    send(ESET, 3, 2, 0, 1, C_OK, "R1 erase setup idle");
    send(CONF, 3, 2, 0, 1, C_OK, "R6 erase confirm");
    check(busy && busy_bank == 3 && busy_erase, "R6 busy on bank 3", int'({busy, busy_bank}), 11);
    send(RD, 5, 0, 0, 1, C_OK, "R2 read other bank");
    send(RD, 0, 0, 0, 1, C_OK, "R2 read bank 0");
    send(RD, 3, 0, 0, 0, C_BUSY, "R3 read busy bank");
    send(PSET, 1, 0, 0, 0, C_BUSY, "R1 program setup while busy");
    send(ESET, 4, 0, 0, 0, C_BUSY, "R1 erase setup while busy");
    finish_op();
    check(!busy, "R9 done clears busy", int'(busy), 0);
    send(RD, 3, 0, 0, 1, C_OK, "R2 read after done");
  endtask

  task automatic t_setup_gap();
    send(CONF, 2, 1, 0, 0, C_BUSY, "R10 confirm without setup");
    send(PSET, 2, 1, 0, 1, C_OK, "R6 program setup");
    send(RD, 2, 0, 0, 1, C_OK, "R6 read same bank in gap");
    send(RD, 6, 0, 0, 1, C_OK, "R6 read other bank in gap");
    send(RDS, 0, 0, 0, 1, C_OK, "R6 special read in gap");
    send(CONF, 7, 9, 0, 1, C_OK, "R6 confirm after reads");
    check(busy && busy_bank == 2 && !busy_erase, "R6 busy bank from setup", int'({busy, busy_bank}), 10);
    send(CONF, 2, 1, 0, 0, C_BUSY, "R1 confirm while busy");
    finish_op();
    send(CONF, 2, 1, 0, 0, C_BUSY, "R10 setup consumed");
  endtask

  task automatic t_suspend_erase();
    send(ESET, 4, 3, 0, 1, C_OK, "R5 erase setup");
    send(CONF, 4, 3, 0, 1, C_OK, "R5 erase confirm");
    send(SUSP, 4, 0, 0, 1, C_OK, "R4 suspend erase");
    check(!busy && susp && susp_bank == 4 && susp_erase, "R4 parked status",
          int'({busy, susp, susp_bank}), 12);
    send(RD, 4, 0, 0, 1, C_OK, "R4 read parked bank");
    send(SUSP, 4, 0, 0, 0, C_SEQ, "R4 suspend with nothing active");
    send(PSET, 4, 3, 0, 0, C_BUSY, "R5 program parked block");
    send(ESET, 1, 0, 0, 0, C_BUSY, "R5 erase while parked");
    send(PSET, 4, 5, 0, 1, C_OK, "R5 program other block same bank");
    send(CONF, 4, 5, 0, 1, C_OK, "R5 program confirm");
    check(busy && busy_bank == 4 && susp, "R5 program plus parked erase",
          int'({busy, susp, busy_bank}), 28);
    send(RD, 6, 0, 0, 1, C_OK, "R2 read third bank");
    send(RES, 4, 0, 0, 0, C_SEQ, "R8 resume while active");
    send(SUSP, 4, 0, 0, 0, C_SEQ, "R4 suspend with one parked");
    finish_op();
    send(RES, 0, 0, 0, 1, C_OK, "R8 resume granted");
    check(busy && busy_bank == 4 && busy_erase && !susp, "R8 resumed erase",
          int'({busy, susp, busy_bank}), 20);
    send(RES, 0, 0, 0, 0, C_SEQ, "R8 resume with nothing parked");
    finish_op();
  endtask

  task automatic t_suspend_prog();
    send(PSET, 5, 0, 0, 1, C_OK, "R5 program setup");
    send(CONF, 5, 0, 0, 1, C_OK, "R5 program confirm");
    send(SUSP, 5, 0, 0, 1, C_OK, "R4 suspend program");
    send(PSET, 6, 1, 0, 0, C_BUSY, "R5 program while program parked");
    send(RES, 5, 0, 0, 1, C_OK, "R8 resume program");
    finish_op();
  endtask

  task automatic t_special();
    send(PSET, 0, 7, 0, 1, C_OK, "R7 setup on param bank");
    send(CONF, 0, 7, 0, 1, C_OK, "R7 confirm on param bank");
    send(RDS, 3, 0, 0, 0, C_SPACE, "R7 special read blocked");
    send(RD, 0, 0, 0, 0, C_BUSY, "R3 read param bank");
    send(RD, 7, 0, 0, 1, C_OK, "R2 read bank 7");
    send(SUSP, 0, 0, 0, 1, C_OK, "R4 suspend param bank");
    send(RDS, 0, 0, 0, 1, C_OK, "R7 special read while parked");
    send(RES, 0, 0, 0, 1, C_OK, "R8 resume param bank");
    finish_op();
    send(ESET, 2, 0, 0, 1, C_OK, "R7 erase setup bank 2");
    send(CONF, 2, 0, 0, 1, C_OK, "R7 erase confirm bank 2");
    send(RDS, 2, 0, 0, 1, C_OK, "R7 special read other bank busy");
    finish_op();
  endtask

  task automatic t_done_tie();
    finish_op();
    check(!busy && !susp && !gnt && !err, "R9 idle completion ignored",
          int'({busy, susp, gnt, err}), 0);
    send(ESET, 3, 1, 0, 1, C_OK, "R9 erase setup");
    send(CONF, 3, 1, 0, 1, C_OK, "R9 erase confirm");
    send(RD, 3, 0, 1, 1, C_OK, "R9 read with same-cycle completion");
    check(!busy, "R9 busy cleared by tie", int'(busy), 0);
    @(negedge clk); req_valid = 1'b1; req_op = 3'd7;
    @(posedge clk); #1; req_valid = 1'b0;
    check(!gnt && !err, "R12 idle op no response", int'({gnt, err}), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst = 1'b0;
    t_dual_read();
    t_setup_gap();
    t_suspend_erase();
    t_suspend_prog();
    t_special();
    t_done_tie();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule